// File: doc/BRIEF.md
# Bit-Serial Gray-Code Ramp Quantizer

This block converts a set of held samples, one per channel, into Gray-coded codewords one bit at a time. A single shared sequencer drives a staircase reference value (the ramp) and a broadcast data bit to every channel. Each channel has one magnitude comparator and one latch. The latch follows the broadcast bit until the ramp first reaches the channel's sample, then holds that bit. Each codeword bit gets its own pass. In that pass the ramp visits only the interval edges at which that Gray bit changes, and the data bit flips at every visit after the first. After each pass the latched bits of all channels leave together as one bit-plane.

A conversion starts with a `start` pulse while the block is idle. The samples, the resolution `m_sel` and the bit order are captured at that pulse. The resolution sets the number of bits `m` per codeword and the number of planes. Each sample is an unsigned `P`-bit fraction `s/2^P`. Interval `i` covers `(i/2^m, (i+1)/2^m]`, and its codeword is the reflected Gray code `i ^ (i>>1)`. Downstream logic rebuilds each channel's codeword from the planes, using `plane_index` to place each bit.

The sequencer has five states. IDLE waits for `start` and goes to SETUP. SETUP clears the ramp, the broadcast bit and every latch, then goes to STEP. STEP walks the boundary points of the current bit and stays there until the last point, then goes to FINAL. FINAL applies a full-scale terminal step and goes to EMIT. EMIT presents the plane for one cycle, then returns to SETUP for the next pass, or to IDLE after the last pass.

Top module: `bitplane_quantizer`

## Requirements
- R1: For a sample `s`, the interval index is `i = 0` when `s == 0` and `(s-1) >> (P-m)` otherwise. The plane with index `k` carries bit `k` of `i ^ (i>>1)` on `plane_data[c]` for channel `c` (channel `c` sample is `samples[c*P +: P]`).
- R2: With `lsb_first = 0` the planes arrive in index order `m-1` down to `0`. With `lsb_first = 1` they arrive from `0` up to `m-1`. `plane_index` always carries the bit number of the plane being presented.
- R3: Within a pass for bit `k`, the ramp starts at zero. It then rises strictly through the values `(2t+1)·2^k·2^(P-m)` for increasing `t`, and ends with one terminal step at `2^P`.
- R4: Once a channel's comparator sees the ramp at or above its sample, its latch holds its bit unchanged until the next clear. By the time a plane is presented, every channel has closed.
- R5: Before every pass the ramp, the broadcast bit and all latches return to zero, so one pass's result never leaks into the next.
- R6: A sample exactly equal to a boundary `j·2^(P-m)` is placed in interval `j-1`. Sample `0` falls in interval 0. Sample `2^P-1` falls in the top interval, whose codeword is a 1 followed by zeros.
- R7: `plane_valid` is high for exactly one cycle per pass and pulses exactly `m` times per conversion. `busy` is low in the cycle after the last plane.
- R8: `start` has no effect while `busy` is high. Neither the samples nor `m_sel` nor the order given then change the running conversion. While idle, no plane is presented.
- R9: An `m_sel` of 0 or above `M_MAX` is treated as `M_MAX`.
- R10: After reset `busy` and `plane_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a conversion when idle |
| m_sel | input | $clog2(M_MAX+1) | Bits per codeword for the conversion |
| lsb_first | input | 1 | 1: planes from bit 0 upward; 0: from the top bit down |
| samples | input | NCH*P | Channel samples, channel c at bits c*P +: P |
| busy | output | 1 | Conversion in progress |
| plane_valid | output | 1 | One-cycle strobe marking a presented bit-plane |
| plane_index | output | $clog2(M_MAX) | Bit number of the presented plane |
| plane_data | output | NCH | One latched bit per channel |

## Verification
Every 6-bit sample value is converted at every resolution from 1 to 4 bits, in both bit orders. This exposes errors in the boundary sets, in the data-bit toggling and in the plane ordering. Samples lying exactly on a boundary, plus zero and full scale, are reported separately. They are the only values that separate a correct `>=` comparison from an off-by-one, and that confirm the terminal step gives the top interval's code. A start pulse with different samples and resolution, issued mid-conversion, must leave the planes unchanged. Out-of-range resolution codes must yield four planes.

// File: rtl/bq_pkg.sv
package bq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STEP,
        ST_FINAL,
        ST_EMIT
    } bq_state_e;
endpackage

// File: rtl/bq_sequencer.sv
module bq_sequencer #(
    parameter int P     = 6,
    parameter int M_MAX = 4,
    parameter int MW    = $clog2(M_MAX + 1),
    parameter int KW    = $clog2(M_MAX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [MW-1:0] m_sel,
    input  logic          lsb_first,
    output logic [P:0]    ramp,
    output logic          bitx,
    output logic          clr,
    output logic          en,
    output logic          load,
    output logic          plane_valid,
    output logic [KW-1:0] plane_index,
    output logic          busy
);
    import bq_pkg::*;

    localparam int TW = M_MAX - 1;   // step counter width
    localparam int RW = P + 1;       // ramp width, holds full scale
    localparam int SW = $clog2(P + 1) + 1;

    bq_state_e      state, nxt;
    logic [MW-1:0]  m_q, m_eff, top_sh;
    logic           lsb_q;
    logic [KW-1:0]  pass_c, k_cur;
    logic [TW-1:0]  t_q;
    logic [TW:0]    steps;
    logic           last_step, last_pass;
    logic [SW-1:0]  shamt;
    logic [RW-1:0]  odd_pt;

    // resolution clamp: zero or oversize selects the widest setting
    assign m_eff = (m_sel == '0 || m_sel > MW'(M_MAX)) ? MW'(M_MAX) : m_sel;

    // bit handled by the current pass
    assign k_cur  = lsb_q ? pass_c : KW'(m_q - MW'(1) - MW'(pass_c));
    // bit k has 2^(m-1-k) boundary points
    assign top_sh = m_q - MW'(1) - MW'(k_cur);
    assign steps  = (TW+1)'(1) << top_sh;
    assign last_step = ({1'b0, t_q} == (steps - (TW+1)'(1)));
    assign last_pass = (pass_c == KW'(m_q - MW'(1)));
    // boundary (2t+1)*2^k on the m-bit grid, scaled to P bits
    assign shamt  = SW'(k_cur) + SW'(P) - SW'(m_q);
    assign odd_pt = RW'({t_q, 1'b1});

    // state register and pass counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            m_q    <= MW'(M_MAX);
            lsb_q  <= 1'b0;
            pass_c <= '0;
            t_q    <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && start) begin
                m_q    <= m_eff;
                lsb_q  <= lsb_first;
                pass_c <= '0;
            end
            if (state == ST_SETUP)
                t_q <= '0;
            if (state == ST_STEP && !last_step)
                t_q <= t_q + TW'(1);
            if (state == ST_EMIT && !last_pass)
                pass_c <= pass_c + KW'(1);
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_SETUP;
            ST_SETUP: nxt = ST_STEP;
            ST_STEP:  if (last_step) nxt = ST_FINAL;
            ST_FINAL: nxt = ST_EMIT;
            ST_EMIT:  nxt = last_pass ? ST_IDLE : ST_SETUP;
            default:  nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ramp        = '0;
        bitx        = 1'b0;
        clr         = 1'b0;
        en          = 1'b0;
        load        = 1'b0;
        plane_valid = 1'b0;
        unique case (state)
            ST_IDLE:  load = start;
            ST_SETUP: clr = 1'b1;
            ST_STEP: begin
                en   = 1'b1;
                ramp = odd_pt << shamt;
                bitx = t_q[0];
            end
            ST_FINAL: begin
                en   = 1'b1;
                ramp = RW'(1) << P;
                bitx = steps[0];
            end
            ST_EMIT:  plane_valid = 1'b1;
            default:  ;
        endcase
    end

    assign plane_index = k_cur;
    assign busy        = (state != ST_IDLE);
endmodule

// File: rtl/bq_channel.sv
module bq_channel #(
    parameter int P = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [P-1:0] smp_in,
    input  logic         clr,
    input  logic         en,
    input  logic [P:0]   ramp,
    input  logic         bitx,
    output logic         bit_q,
    output logic         closed_q
);
    logic [P-1:0] smp_q;
    logic         reached;

    // comparator: ramp at or above the held sample
    assign reached = ({1'b0, smp_q} <= ramp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q    <= '0;
            bit_q    <= 1'b0;
            closed_q <= 1'b0;
        end else begin
            if (load)
                smp_q <= smp_in;
            if (clr) begin
                bit_q    <= 1'b0;
                closed_q <= 1'b0;
            end else if (en && !closed_q) begin
                bit_q <= bitx;
                if (reached)
                    closed_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/bitplane_quantizer.sv
module bitplane_quantizer #(
    parameter int NCH   = 4,
    parameter int P     = 6,
    parameter int M_MAX = 4,
    parameter int MW    = $clog2(M_MAX + 1),
    parameter int KW    = $clog2(M_MAX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [MW-1:0]    m_sel,
    input  logic             lsb_first,
    input  logic [NCH*P-1:0] samples,
    output logic             busy,
    output logic             plane_valid,
    output logic [KW-1:0]    plane_index,
    output logic [NCH-1:0]   plane_data
);
    logic [P:0]     ramp_w;
    logic           bitx_w, clr_w, en_w, load_w;
    logic [NCH-1:0] closed_w;

    bq_sequencer #(.P(P), .M_MAX(M_MAX), .MW(MW), .KW(KW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .m_sel       (m_sel),
        .lsb_first   (lsb_first),
        .ramp        (ramp_w),
        .bitx        (bitx_w),
        .clr         (clr_w),
        .en          (en_w),
        .load        (load_w),
        .plane_valid (plane_valid),
        .plane_index (plane_index),
        .busy        (busy)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        bq_channel #(.P(P)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_w),
            .smp_in   (samples[c*P +: P]),
            .clr      (clr_w),
            .en       (en_w),
            .ramp     (ramp_w),
            .bitx     (bitx_w),
            .bit_q    (plane_data[c]),
            .closed_q (closed_w[c])
        );
    end
endmodule

// File: rtl/bq_checker.sv
module bq_checker #(
    parameter int NCH = 4,
    parameter int P   = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           clr,
    input logic           en,
    input logic [P:0]     ramp,
    input logic           busy,
    input logic           plane_valid,
    input logic [NCH-1:0] bits,
    input logic [NCH-1:0] closed
);
    p_ramp_rising_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (!en || ramp > $past(ramp)));

    p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (((bits ^ $past(bits)) & $past(closed)) == '0));

    p_all_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        plane_valid |-> (&closed));

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (closed == '0 && bits == '0));

    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        plane_valid |=> !plane_valid);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!plane_valid && !en));
endmodule

bind bitplane_quantizer bq_checker #(.NCH(NCH), .P(P)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr_w),
    .en          (en_w),
    .ramp        (ramp_w),
    .busy        (busy),
    .plane_valid (plane_valid),
    .bits        (plane_data),
    .closed      (closed_w)
);

// File: tb/sim_bitplane_quantizer.sv
`timescale 1ns/1ps
module sim_bitplane_quantizer;
    localparam int NCH = 4;
    localparam int P   = 6;
    localparam int MM  = 4;
    localparam int MW  = $clog2(MM + 1);
    localparam int KW  = $clog2(MM);
    localparam int LIMIT = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [MW-1:0]    m_sel = '0;
    logic             lsb_first = 1'b0;
    logic [NCH*P-1:0] samples = '0;
    logic             busy, plane_valid;
    logic [KW-1:0]    plane_index;
    logic [NCH-1:0]   plane_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit timed_out = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bitplane_quantizer #(.NCH(NCH), .P(P), .M_MAX(MM)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .m_sel(m_sel),
        .lsb_first(lsb_first), .samples(samples), .busy(busy),
        .plane_valid(plane_valid), .plane_index(plane_index),
        .plane_data(plane_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic int exp_code(input int s, input int m);
        int i;
        i = (s == 0) ? 0 : ((s - 1) >> (P - m));
        return i ^ (i >> 1);
    endfunction

    // runs one conversion; poke issues a start with other settings mid-run
    task automatic run_conv(input int msel, input bit lsb, input logic [NCH*P-1:0] smp,
                            input int m_exp, input bit poke);
        int got[NCH];
        int planes;
        int iter;
        bit prev_pv;
        int kexp;
        for (int c = 0; c < NCH; c++) got[c] = 0;
        @(negedge clk);
        m_sel = MW'(msel); lsb_first = lsb; samples = smp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        planes = 0; iter = 0; prev_pv = 1'b0;
        while (planes < m_exp) begin
            if (cyc > LIMIT) begin
                timed_out = 1'b1;
                return;
            end
            @(negedge clk);
            iter++;
            if (poke && iter == 3) begin
                start = 1'b1; m_sel = MW'(1); lsb_first = ~lsb; samples = ~smp;
            end else if (poke && iter == 4) begin
                start = 1'b0;
            end
            if (plane_valid) begin
                kexp = lsb ? planes : (m_exp - 1 - planes);
                chk(!prev_pv, "R7 single-cycle plane strobe", 1, 0);
                chk(int'(plane_index) == kexp, poke ? "R8 order kept" : "R2 plane order",
                    int'(plane_index), kexp);
                for (int c = 0; c < NCH; c++)
                    if (plane_data[c]) got[c] |= (1 << int'(plane_index));
                planes++;
            end
            prev_pv = plane_valid;
        end
        @(negedge clk);
        chk(!busy && !plane_valid, "R7 done after m planes", int'(busy), 0);
        for (int c = 0; c < NCH; c++) begin
            int s;
            int e;
            s = int'(smp[c*P +: P]);
            e = exp_code(s, m_exp);
            if (poke)
                chk(got[c] == e, "R8 ignored start", got[c], e);
            else if (s == 0 || s == (1 << P) - 1 || (s % (1 << (P - m_exp))) == 0)
                chk(got[c] == e, "R6 boundary R4", got[c], e);
            else
                chk(got[c] == e, "R1 codeword R3 R5", got[c], e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R10 reset busy", int'(busy), 0);
        chk(plane_valid == 1'b0, "R10 reset valid", int'(plane_valid), 0);
        rst_n = 1'b1;

        // R8: idle with start low presents nothing
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            if (plane_valid || busy) chk(1'b0, "R8 idle quiet", 1, 0);
        end
        chk(!busy, "R8 idle busy", int'(busy), 0);

        // exhaustive sweep: all samples, all resolutions, both orders
        for (int m = 1; m <= MM; m++) begin
            for (int o = 0; o < 2; o++) begin
                for (int b = 0; b < (1 << P); b += NCH) begin
                    logic [NCH*P-1:0] v;
                    for (int c = 0; c < NCH; c++) v[c*P +: P] = P'(b + c);
                    if (!timed_out) run_conv(m, o[0], v, m, 1'b0);
                end
            end
        end

        // R9: out-of-range resolution codes act as the widest setting
        if (!timed_out) run_conv(0, 1'b0, {6'd63, 6'd40, 6'd17, 6'd1}, MM, 1'b0);
        if (!timed_out) run_conv(7, 1'b1, {6'd0, 6'd32, 6'd33, 6'd48}, MM, 1'b0);
        if (!timed_out) run_conv(5, 1'b0, {6'd5, 6'd12, 6'd24, 6'd60}, MM, 1'b0);
        chk(!timed_out, "R9 clamp run", int'(timed_out), 0);

        // R8: start during a conversion is ignored
        if (!timed_out) run_conv(3, 1'b0, {6'd9, 6'd24, 6'd25, 6'd62}, 3, 1'b1);
        if (!timed_out) run_conv(4, 1'b1, {6'd3, 6'd16, 6'd47, 6'd63}, 4, 1'b1);

        if (timed_out) chk(1'b0, "R7 watchdog expired", cyc, LIMIT);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule